// File: doc/BRIEF.md
# MDIO Management Frame Engine

This block carries out one management transaction at a time to an external PHY over the two-wire MDIO/MDC pair. Software writes a packed 32-bit command word while the management port is enabled. The block then drives a preamble of ones followed by the command word, most significant bit first, on MDIO. MDC is produced by dividing the system clock by a selectable power of two. For a read, the block gives up the data line at the turnaround and writes the 16 bits returned by the PHY into the low half of the command word. Software reads them back from `cmd_rdata`.

Command word fields: the start code (01) is in 31:30, the operation is in 29:28 (10 = read, 01 = write), the PHY address is in 27:23, the register address is in 22:18, the turnaround field (written as 10) is in 17:16, and the data is in 15:0. Only the operation field is decoded. Every other field is sent as written.

Control is a three-state machine. `ST_IDLE` goes to `ST_PREAMBLE` on an accepted command write. `ST_PREAMBLE` goes to `ST_FRAME` on the MDC falling edge that ends the 32nd preamble bit. `ST_FRAME` goes back to `ST_IDLE` on the falling edge that ends the 32nd frame bit. Each state otherwise holds.

Top module: `mdio_mgmt_ctrl`

## Requirements
- R1: After reset, `idle`=1, `mdc`=0, `mdio_oe`=0, `mdio_o`=1 and `cmd_rdata`=0.
- R2: A `cmd_we` pulse while `idle`=1 and `mgmt_en`=1 starts a transaction, and `idle` is low in the following cycle.
- R3: A `cmd_we` pulse while `mgmt_en`=0 has no effect. `idle` stays high, MDC does not toggle and `cmd_rdata` keeps its value.
- R4: Every transaction begins with 32 MDC periods in which MDIO is driven to 1.
- R5: After the preamble, the command word is driven MSB first from bit 31. For a write (bits 29:28 = 01), all 32 bits are driven.
- R6: For a read (bits 29:28 = 10), the output enable drops at the first turnaround bit (command bit 17). Only bits 31:18 are driven after the preamble.
- R7: After a read, `cmd_rdata[15:0]` holds the 16 bits sampled from `mdio_i`, first-received in bit 15. Bits 31:16 are unchanged. After a write, `cmd_rdata` equals the written word.
- R8: MDC has a period of 8, 16, 32 or 64 system clocks for `clk_sel` = 0, 1, 2, 3, with a 50% duty cycle. `clk_sel` is captured at start.
- R9: `mdio_o` changes only in the cycle in which MDC falls. `mdio_i` is sampled where MDC rises.
- R10: A `cmd_we` pulse while a transaction is in progress is ignored. The frame and the final `cmd_rdata` are those of the first command.
- R11: A transaction keeps `idle` low for exactly 64 MDC periods, then `idle` returns high and MDC rests low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_we | input | 1 | Command write strobe |
| cmd_wdata | input | 32 | Command word |
| mgmt_en | input | 1 | Management port enable |
| clk_sel | input | 2 | MDC divider select (8/16/32/64) |
| mdio_i | input | 1 | MDIO input from the pad |
| mdc | output | 1 | Management clock |
| mdio_o | output | 1 | MDIO output value |
| mdio_oe | output | 1 | MDIO output enable |
| cmd_rdata | output | 32 | Command word readback, with read data in 15:0 |
| idle | output | 1 | High when no transaction is in progress |

## Verification
The in-RTL assertions check several rules on every cycle. MDIO stays driven high through the preamble. A read keeps the output enable released from the turnaround onward. `mdio_o` moves only with a falling MDC. MDC rests low whenever the engine is idle. Busy writes leave the held command untouched. Some behaviour can only be shown by the bench scenarios, because it depends on whole transactions: the exact bit stream, the captured read data, the MDC period for each divider setting, the total transaction length, and the silence under a disabled port. The bench checks these against a behavioural PHY model.

// File: rtl/mdio_pkg.sv
package mdio_pkg;

    localparam int CMD_W      = 32;
    localparam int PRE_LEN    = 32;
    localparam int DATA_W     = 16;
    localparam int CNT_W      = $clog2(CMD_W);
    localparam int TA_IDX     = CMD_W - DATA_W - 2;
    localparam int DATA_IDX   = CMD_W - DATA_W;
    localparam int OP_HI      = 29;
    localparam int OP_LO      = 28;

    localparam logic [1:0] OP_READ  = 2'b10;
    localparam logic [1:0] OP_WRITE = 2'b01;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_PREAMBLE,
        ST_FRAME
    } seq_state_t;

endpackage

// File: rtl/mdio_clk_div.sv
module mdio_clk_div #(
    parameter int SEL_W    = 2,
    parameter int BASE_LOG = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [SEL_W-1:0] sel,
    output logic             mdc,
    output logic             rise_tick,
    output logic             fall_tick
);

    localparam int CNT_W = BASE_LOG + (1 << SEL_W) - 2;

    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] last_cnt;
    logic             tick;

    always_comb begin
        last_cnt  = CNT_W'((1 << (BASE_LOG - 1 + int'(sel))) - 1);
        tick      = run && (cnt == last_cnt);
        rise_tick = tick && !mdc;
        fall_tick = tick && mdc;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
            mdc <= 1'b0;
        end else if (!run) begin
            cnt <= '0;
            mdc <= 1'b0;
        end else if (tick) begin
            cnt <= '0;
            mdc <= ~mdc;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end

    assert_mdc_rests_low_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> !mdc)
        else $error("MDC toggled while not running");

endmodule

// File: rtl/mdio_frame_seq.sv
module mdio_frame_seq
    import mdio_pkg::*;
#(
    parameter int SEL_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_we,
    input  logic [CMD_W-1:0]  cmd_wdata,
    input  logic              mgmt_en,
    input  logic [SEL_W-1:0]  clk_sel,
    input  logic              rise_tick,
    input  logic              fall_tick,
    input  logic              mdio_i,
    output logic              run,
    output logic [SEL_W-1:0]  sel_q,
    output logic              mdio_o,
    output logic              mdio_oe,
    output logic [CMD_W-1:0]  cmd_q,
    output logic              idle
);

    seq_state_t       state, state_nxt;
    logic [CNT_W-1:0] bit_cnt;
    logic [CNT_W-1:0] bit_nxt;
    logic             start;
    logic             last_bit;
    logic             is_read;

    always_comb begin
        start    = cmd_we && mgmt_en && (state == ST_IDLE);
        last_bit = (bit_cnt == CNT_W'(CMD_W - 1));
        bit_nxt  = bit_cnt + 1'b1;
        is_read  = (cmd_q[OP_HI:OP_LO] == OP_READ);
        idle     = (state == ST_IDLE);
        run      = (state != ST_IDLE);
    end

    always_comb begin
        state_nxt = state;
        unique case (state)
            ST_IDLE:     if (start)                 state_nxt = ST_PREAMBLE;
            ST_PREAMBLE: if (fall_tick && last_bit) state_nxt = ST_FRAME;
            ST_FRAME:    if (fall_tick && last_bit) state_nxt = ST_IDLE;
            default:                                state_nxt = ST_IDLE;
        endcase
    end

    // state register and bit position
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state   <= ST_IDLE;
            bit_cnt <= '0;
        end else begin
            state <= state_nxt;
            if (start)
                bit_cnt <= '0;
            else if (fall_tick && state != ST_IDLE)
                bit_cnt <= bit_nxt;
        end
    end

    // outputs and command register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cmd_q   <= '0;
            sel_q   <= '0;
            mdio_o  <= 1'b1;
            mdio_oe <= 1'b0;
        end else begin
            unique case (state)
                ST_IDLE: begin
                    if (start) begin
                        cmd_q   <= cmd_wdata;
                        sel_q   <= clk_sel;
                        mdio_o  <= 1'b1;
                        mdio_oe <= 1'b1;
                    end
                end
                ST_PREAMBLE: begin
                    if (fall_tick && last_bit)
                        mdio_o <= cmd_q[CMD_W-1];
                end
                ST_FRAME: begin
                    if (rise_tick && is_read && bit_cnt >= CNT_W'(DATA_IDX))
                        cmd_q[CNT_W'(CMD_W - 1) - bit_cnt] <= mdio_i;
                    if (fall_tick) begin
                        if (last_bit) begin
                            mdio_o  <= 1'b1;
                            mdio_oe <= 1'b0;
                        end else if (is_read && bit_nxt >= CNT_W'(TA_IDX)) begin
                            mdio_o  <= 1'b1;
                            mdio_oe <= 1'b0;
                        end else begin
                            mdio_o  <= cmd_q[CNT_W'(CMD_W - 1) - bit_nxt];
                        end
                    end
                end
                default: begin
                    mdio_oe <= 1'b0;
                end
            endcase
        end
    end

    assert_start_leaves_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> !idle)
        else $error("accepted command did not start");

    assert_preamble_driven_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_PREAMBLE) |-> (mdio_o && mdio_oe))
        else $error("preamble not driven high");

    assert_read_releases_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_FRAME && is_read && bit_cnt >= CNT_W'(TA_IDX)) |-> !mdio_oe)
        else $error("output enable held during read turnaround/data");

    assert_busy_write_ignored_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_we && state != ST_IDLE) |=> $stable(cmd_q[CMD_W-1:DATA_W]))
        else $error("busy write disturbed command");

endmodule

// File: rtl/mdio_mgmt_ctrl.sv
module mdio_mgmt_ctrl
    import mdio_pkg::*;
#(
    parameter int SEL_W    = 2,
    parameter int BASE_LOG = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_we,
    input  logic [CMD_W-1:0]  cmd_wdata,
    input  logic              mgmt_en,
    input  logic [SEL_W-1:0]  clk_sel,
    input  logic              mdio_i,
    output logic              mdc,
    output logic              mdio_o,
    output logic              mdio_oe,
    output logic [CMD_W-1:0]  cmd_rdata,
    output logic              idle
);

    logic             run;
    logic             rise_tick;
    logic             fall_tick;
    logic [SEL_W-1:0] sel_q;

    mdio_clk_div #(
        .SEL_W    (SEL_W),
        .BASE_LOG (BASE_LOG)
    ) u_div (
        .clk       (clk),
        .rst_n     (rst_n),
        .run       (run),
        .sel       (sel_q),
        .mdc       (mdc),
        .rise_tick (rise_tick),
        .fall_tick (fall_tick)
    );

    mdio_frame_seq #(
        .SEL_W (SEL_W)
    ) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .cmd_we    (cmd_we),
        .cmd_wdata (cmd_wdata),
        .mgmt_en   (mgmt_en),
        .clk_sel   (clk_sel),
        .rise_tick (rise_tick),
        .fall_tick (fall_tick),
        .mdio_i    (mdio_i),
        .run       (run),
        .sel_q     (sel_q),
        .mdio_o    (mdio_o),
        .mdio_oe   (mdio_oe),
        .cmd_q     (cmd_rdata),
        .idle      (idle)
    );

    assert_mdio_moves_on_fall_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(mdio_o) |-> $fell(mdc))
        else $error("MDIO changed away from MDC falling edge");

endmodule

// File: tb/test_mdio_mgmt_ctrl.sv
module test_mdio_mgmt_ctrl;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        cmd_we = 1'b0;
    logic [31:0] cmd_wdata = '0;
    logic        mgmt_en = 1'b1;
    logic [1:0]  clk_sel = '0;
    logic        mdio_i = 1'b1;
    logic        mdc;
    logic        mdio_o;
    logic        mdio_oe;
    logic [31:0] cmd_rdata;
    logic        idle;

    int n_run  = 0;
    int n_fail = 0;

    always #5 clk = ~clk;

    mdio_mgmt_ctrl i_mdio_mgmt_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .cmd_we    (cmd_we),
        .cmd_wdata (cmd_wdata),
        .mgmt_en   (mgmt_en),
        .clk_sel   (clk_sel),
        .mdio_i    (mdio_i),
        .mdc       (mdc),
        .mdio_o    (mdio_o),
        .mdio_oe   (mdio_oe),
        .cmd_rdata (cmd_rdata),
        .idle      (idle)
    );

    // PHY model: cumulative counters, sampled by snapshot
    logic [15:0] phy_data = '0;
    int          rise_n = 0;
    int          oe_n   = 0;
    int          rise_base = 0;
    logic [63:0] cap = '0;

    always @(posedge mdc) begin
        rise_n = rise_n + 1;
        if (mdio_oe) begin
            cap  = {cap[62:0], mdio_o};
            oe_n = oe_n + 1;
        end
    end

    always @(negedge mdc) begin
        if (rise_n - rise_base >= 48 && rise_n - rise_base <= 63)
            mdio_i = phy_data[63 - (rise_n - rise_base)];
        else
            mdio_i = 1'b1;
    end

    int   busy_cyc = 0;
    int   high_cyc = 0;
    int   bad_edge = 0;
    logic prev_o   = 1'b1;
    logic prev_mdc = 1'b0;

    always @(negedge clk) begin
        if (rst_n === 1'b1) begin
            if (!idle) busy_cyc = busy_cyc + 1;
            if (mdc)   high_cyc = high_cyc + 1;
            if (mdio_o !== prev_o && !(prev_mdc && !mdc)) bad_edge = bad_edge + 1;
        end
        prev_o   = mdio_o;
        prev_mdc = mdc;
    end

    task automatic check(input bit ok, input string req, input logic [63:0] act,
                         input logic [63:0] exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    function automatic bit is_rd(input logic [31:0] c);
        return c[29:28] == 2'b10;
    endfunction

    function automatic int exp_oe(input logic [31:0] c);
        return is_rd(c) ? 46 : 64;
    endfunction

    function automatic logic [63:0] exp_bits(input logic [31:0] c);
        return is_rd(c) ? {18'b0, 32'hFFFF_FFFF, c[31:18]} : {32'hFFFF_FFFF, c};
    endfunction

    function automatic logic [31:0] exp_rd(input logic [31:0] c, input logic [15:0] pd);
        return is_rd(c) ? {c[31:16], pd} : c;
    endfunction

    function automatic logic [31:0] mk_cmd(input bit rd, input logic [4:0] pa,
                                           input logic [4:0] ra, input logic [15:0] d);
        return {2'b01, rd ? 2'b10 : 2'b01, pa, ra, 2'b10, d};
    endfunction

    task automatic run_txn(input logic [31:0] c, input logic [1:0] s,
                           input logic [15:0] pd, input bit poke_busy);
        int r0, o0, b0, h0, e0, per, n;
        logic [63:0] mask, got;
        r0 = rise_n; o0 = oe_n; b0 = busy_cyc; h0 = high_cyc; e0 = bad_edge;
        rise_base = rise_n;
        phy_data  = pd;
        clk_sel   = s;
        cmd_wdata = c;
        cmd_we    = 1'b1;
        @(negedge clk);
        cmd_we = 1'b0;
        check(idle == 1'b0, "R2 idle low after start", 64'(idle), 64'd0);
        n = 0;
        while (!idle) begin
            @(negedge clk);
            n++;
            if (poke_busy && n == 50) begin
                cmd_wdata = ~c;
                clk_sel   = ~s;
                cmd_we    = 1'b1;
            end else begin
                cmd_we = 1'b0;
            end
        end
        cmd_we = 1'b0;
        per  = 8 << s;
        mask = (64'd1 << exp_oe(c)) - 64'd1;
        if (exp_oe(c) == 64) mask = '1;
        got  = cap & mask;
        check(((got >> (exp_oe(c) - 32)) & 64'hFFFF_FFFF) == 64'hFFFF_FFFF,
              "R4 preamble ones", got >> (exp_oe(c) - 32), 64'hFFFF_FFFF);
        check(got == exp_bits(c), poke_busy ? "R10 frame of first command" : "R5 frame bits",
              got, exp_bits(c));
        check(oe_n - o0 == exp_oe(c), "R6 driven bit count", 64'(oe_n - o0), 64'(exp_oe(c)));
        check(cmd_rdata == exp_rd(c, pd), poke_busy ? "R10 readback" : "R7 readback",
              64'(cmd_rdata), 64'(exp_rd(c, pd)));
        check(high_cyc - h0 == 32 * per, "R8 MDC high time", 64'(high_cyc - h0), 64'(32 * per));
        check(rise_n - r0 == 64, "R8 MDC period count", 64'(rise_n - r0), 64'd64);
        check(bad_edge == e0, "R9 MDIO change off falling edge", 64'(bad_edge - e0), 64'd0);
        check(busy_cyc - b0 == 64 * per, "R11 busy length", 64'(busy_cyc - b0), 64'(64 * per));
        check(mdc == 1'b0, "R11 MDC rests low", 64'(mdc), 64'd0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        logic [31:0] keep;
        void'($urandom(32'd20240611));
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        check(idle == 1'b1 && mdc == 1'b0 && mdio_oe == 1'b0 && mdio_o == 1'b1,
              "R1 reset outputs", {60'd0, idle, mdc, mdio_oe, mdio_o}, 64'h9);
        check(cmd_rdata == 32'd0, "R1 reset readback", 64'(cmd_rdata), 64'd0);
        rst_n = 1'b1;
        @(negedge clk);

        // directed corner cases
        run_txn(mk_cmd(1'b0, 5'h01, 5'h00, 16'h8001), 2'd0, 16'h0000, 1'b0);
        run_txn(mk_cmd(1'b1, 5'h1F, 5'h1F, 16'h0000), 2'd0, 16'hA5C3, 1'b0);
        run_txn(mk_cmd(1'b1, 5'h00, 5'h02, 16'h1234), 2'd1, 16'hFFFF, 1'b0);
        run_txn(mk_cmd(1'b1, 5'h10, 5'h03, 16'hFFFF), 2'd2, 16'h0000, 1'b0);
        run_txn(mk_cmd(1'b0, 5'h15, 5'h0A, 16'h5A5A), 2'd3, 16'h0000, 1'b0);

        // command written while busy is ignored (R10)
        run_txn(mk_cmd(1'b0, 5'h03, 5'h04, 16'hC0DE), 2'd0, 16'h0000, 1'b1);

        // disabled port ignores writes (R3)
        keep      = cmd_rdata;
        mgmt_en   = 1'b0;
        begin
            int b0, r0;
            b0 = busy_cyc; r0 = rise_n;
            cmd_wdata = mk_cmd(1'b1, 5'h07, 5'h07, 16'h0);
            cmd_we    = 1'b1;
            @(negedge clk);
            cmd_we = 1'b0;
            repeat (100) @(negedge clk);
            check(busy_cyc == b0, "R3 idle stays high", 64'(busy_cyc - b0), 64'd0);
            check(rise_n == r0, "R3 MDC quiet", 64'(rise_n - r0), 64'd0);
            check(cmd_rdata == keep, "R3 readback unchanged", 64'(cmd_rdata), 64'(keep));
        end
        mgmt_en = 1'b1;
        @(negedge clk);

        // constrained random
        for (int i = 0; i < 10; i++) begin
            logic [31:0] c;
            c = mk_cmd(1'($urandom), 5'($urandom), 5'($urandom), 16'($urandom));
            run_txn(c, 2'($urandom % 2), 16'($urandom), 1'b0);
        end

        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule